// File: doc/BRIEF.md
# Tag Address Map Register File

This block holds the two 64-bit configuration words that place a cell storage window in the address space. Software reaches them over a simple register bus in 8-byte slots. Each word accepts writes only into its writable fields. All other bits keep their old value, including a read-only cell-count field in the second word. From the stored words the block continuously derives the window base, window size, window enable and the power-of-two stride between storage cells.

A one-cycle reconfigure pulse tells the downstream remapping logic that a write really altered a word. A write that leaves both words unchanged raises no pulse.

The block also decodes a storage-side address. It returns the cell that the address selects and the four-bit access view that the address carries. The cell index is clamped, so an address beyond the last cell still maps onto the last cell.

Top module: `tagmap_regfile`

## Requirements
- R1: The register slot is `reg_addr >> 3`; byte-offset bits 2:0 are ignored. Slot 0 and slot 1 read back their stored words through `reg_rdata` in the same cycle. A read of any other slot returns zero, and `reg_rd_err` is high in that cycle while `reg_rd_en` is high. `reg_rd_err` stays low for slots 0 and 1.
- R2: A write to slot 0 changes only bits 31:10 (base) and bit 0 (enable). Every other bit keeps its previous value.
- R3: A write to slot 1 changes only bits 16:10 (size field) and bits 2:0 (grain). Every other bit keeps its previous value, including the cell-count field at bits 31:20.
- R4: A write to any slot other than 0 or 1 changes no stored bit, and it raises no reconfigure pulse.
- R5: `rcfg_pulse` is high for exactly the one cycle after a write clock edge whose merged value differs from the stored value. It is low otherwise.
- R6: `win_base` = slot0[31:10] shifted left by 10, and `win_en` = slot0[0]. `win_size` = 1024 + (slot1 & 0x1FC00).
- R7: `win_shift` = 7 + slot1[2:0]. `cell_idx` = `st_addr >> win_shift`, clamped to NUM_CELLS-1.
- R8: `st_view` = `st_addr[6:3]`.
- R9: After reset, slot 0 reads 0. Slot 1 reads 0xC00 with NUM_CELLS placed at bit 20. `rcfg_pulse` is 0, and `win_size` is 4096.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (qualifies the error flag) |
| reg_addr | input | RA_W | Register byte address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for the addressed slot |
| reg_rd_err | output | 1 | Read of an unimplemented slot |
| rcfg_pulse | output | 1 | One-cycle pulse after a changing write |
| win_base | output | 32 | Storage window base address |
| win_size | output | 18 | Storage window size in bytes |
| win_en | output | 1 | Storage window enable |
| win_shift | output | 4 | Log2 of the cell stride |
| st_addr | input | ST_AW | Storage-side offset address |
| cell_idx | output | CIDX_W | Selected cell, clamped |
| st_view | output | 4 | Access view code |

## Verification
The hardest situation to reach is the case where the clamp and the truncated address interact at large grains. There, a shifted address can land well past the last cell or wrap within the address width. The bench programs every grain value in turn. For each grain it sweeps cell positions beyond NUM_CELLS, at several views and offsets, and builds addresses whose top bits fall off. The second hard point is a write that matches the stored value and must stay silent. Repeated masked writes, and writes whose only changes lie outside the mask, cover that case.

// File: rtl/tagmap_pkg.sv
// Package: shared constants and the derived window type for the tag
// address map register file. Assumes 64-bit register words.
package tagmap_pkg;
    localparam int unsigned WORD_W     = 64;
    localparam int unsigned SLOT_SHIFT = 3;
    localparam int unsigned SIZE_W     = 18;
    localparam int unsigned BASE_W     = 32;
    localparam int unsigned STRIDE_MIN = 7;
    localparam int unsigned CNT_POS    = 20;
    localparam int unsigned VIEW_LSB   = 3;
    localparam int unsigned VIEW_W     = 4;

    localparam logic [WORD_W-1:0] SLOT0_MASK = 64'h0000_0000_FFFF_FC01;
    localparam logic [WORD_W-1:0] SLOT1_MASK = 64'h0000_0000_0001_FC07;
    localparam logic [WORD_W-1:0] SIZE_FIELD = 64'h0000_0000_0001_FC00;
    localparam logic [WORD_W-1:0] SPAN_RST   = 64'h0000_0000_0000_0FFF & SIZE_FIELD;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [SIZE_W-1:0] size;
        logic              en;
        logic [3:0]        shift;
    } win_cfg_t;
endpackage

// File: rtl/tagmap_store.sv
// Module: tagmap_store
// Holds the address-map words, merges writes under per-slot masks,
// raises a change pulse and serves combinational reads.
// Assumes NUM_REGS == 2 (mask table covers slots 0 and 1).
module tagmap_store
    import tagmap_pkg::*;
#(
    parameter int unsigned RA_W      = 6,
    parameter int unsigned NUM_REGS  = 2,
    parameter int unsigned NUM_CELLS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [RA_W-1:0]   addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              rd_err,
    output logic              chg_pulse,
    output logic [WORD_W-1:0] word0,
    output logic [WORD_W-1:0] word1
);
    localparam int unsigned IDX_W = RA_W - SLOT_SHIFT;
    localparam logic [WORD_W-1:0] CNT_VAL = WORD_W'(NUM_CELLS) << CNT_POS;

    logic [WORD_W-1:0] regs_q [NUM_REGS];
    logic [WORD_W-1:0] merged [NUM_REGS];
    logic [NUM_REGS-1:0] hit, diff;
    logic [IDX_W-1:0] idx;

    function automatic logic [WORD_W-1:0] mask_of(input int unsigned i);
        return (i == 0) ? SLOT0_MASK : SLOT1_MASK;
    endfunction

    function automatic logic [WORD_W-1:0] rst_of(input int unsigned i);
        return (i == 0) ? '0 : (SPAN_RST | CNT_VAL);
    endfunction

    assign idx = addr[RA_W-1:SLOT_SHIFT];

    // Per-slot hit, masked merge and change detection.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        assign hit[g]    = wr_en && (32'(idx) == g);
        assign merged[g] = (wdata & mask_of(g)) | (regs_q[g] & ~mask_of(g));
        assign diff[g]   = hit[g] && (merged[g] != regs_q[g]);
    end

    // Register update and change pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= rst_of(i);
            chg_pulse <= 1'b0;
        end else begin
            for (int i = 0; i < NUM_REGS; i++)
                if (hit[i]) regs_q[i] <= merged[i];
            chg_pulse <= |diff;
        end
    end

    // Combinational read with out-of-range flag.
    always_comb begin
        rdata  = '0;
        rd_err = 1'b0;
        if (32'(idx) < NUM_REGS) rdata = regs_q[idx[0]];
        else                     rd_err = rd_en;
    end

    assign word0 = regs_q[0];
    assign word1 = regs_q[1];

    assert_quiet_without_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> ($stable(word0) && $stable(word1) && !chg_pulse));
    assert_pulse_means_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
        chg_pulse |-> (word0 != $past(word0) || word1 != $past(word1)));
    assert_rderr_only_oob_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> (rd_en && rdata == '0));
    assert_ro_fields_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((word1 & ~SLOT1_MASK) == $past(word1 & ~SLOT1_MASK)));
endmodule

// File: rtl/tagmap_window.sv
// Module: tagmap_window
// Derives the storage window (base, size, enable, stride shift) from
// the two stored words. Pure combinational.
module tagmap_window
    import tagmap_pkg::*;
(
    input  logic [WORD_W-1:0] word0,
    input  logic [WORD_W-1:0] word1,
    output win_cfg_t          cfg
);
    // Field extraction and size/stride arithmetic.
    always_comb begin
        cfg.base  = {word0[31:10], 10'b0};
        cfg.en    = word0[0];
        cfg.size  = SIZE_W'(1024) + SIZE_W'(word1 & SIZE_FIELD);
        cfg.shift = 4'(STRIDE_MIN) + {1'b0, word1[2:0]};
    end

    always_comb begin
        assert_size_min_R6: assert (cfg.size >= SIZE_W'(1024));
        assert_shift_range_R7: assert (cfg.shift >= 4'd7);
    end
endmodule

// File: rtl/tagmap_celldec.sv
// Module: tagmap_celldec
// Splits a storage address into a clamped cell index and a view code.
// Assumes NUM_CELLS >= 2 and shift <= 14.
module tagmap_celldec
    import tagmap_pkg::*;
#(
    parameter int unsigned ST_AW     = 16,
    parameter int unsigned NUM_CELLS = 32,
    localparam int unsigned CIDX_W   = $clog2(NUM_CELLS)
) (
    input  logic [ST_AW-1:0]  st_addr,
    input  logic [3:0]        shift,
    output logic [CIDX_W-1:0] cell_idx,
    output logic [VIEW_W-1:0] view
);
    localparam logic [ST_AW-1:0] LAST = ST_AW'(NUM_CELLS - 1);
    logic [ST_AW-1:0] raw;

    // Shift by stride and clamp to the last cell.
    always_comb begin
        raw      = st_addr >> shift;
        cell_idx = (raw > LAST) ? CIDX_W'(NUM_CELLS - 1) : raw[CIDX_W-1:0];
        view     = st_addr[VIEW_LSB +: VIEW_W];
    end

    always_comb begin
        assert_clamp_R7: assert (32'(cell_idx) <= NUM_CELLS - 1);
    end
endmodule

// File: rtl/tagmap_regfile.sv
// Module: tagmap_regfile (top)
// Address-map register file: masked register store, derived window
// outputs and storage address decode. Synchronous active-low reset.
module tagmap_regfile
    import tagmap_pkg::*;
#(
    parameter int unsigned RA_W      = 6,
    parameter int unsigned ST_AW     = 16,
    parameter int unsigned NUM_CELLS = 32,
    localparam int unsigned CIDX_W   = $clog2(NUM_CELLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    output logic              reg_rd_err,
    output logic              rcfg_pulse,
    output logic [31:0]       win_base,
    output logic [17:0]       win_size,
    output logic              win_en,
    output logic [3:0]        win_shift,
    input  logic [ST_AW-1:0]  st_addr,
    output logic [CIDX_W-1:0] cell_idx,
    output logic [3:0]        st_view
);
    logic [WORD_W-1:0] w0, w1;
    win_cfg_t cfg;

    tagmap_store #(.RA_W(RA_W), .NUM_REGS(2), .NUM_CELLS(NUM_CELLS)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .rd_en(reg_rd_en),
        .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .rd_err(reg_rd_err), .chg_pulse(rcfg_pulse), .word0(w0), .word1(w1)
    );

    tagmap_window u_win (.word0(w0), .word1(w1), .cfg(cfg));

    tagmap_celldec #(.ST_AW(ST_AW), .NUM_CELLS(NUM_CELLS)) u_dec (
        .st_addr(st_addr), .shift(cfg.shift), .cell_idx(cell_idx), .view(st_view)
    );

    assign win_base  = cfg.base;
    assign win_size  = cfg.size;
    assign win_en    = cfg.en;
    assign win_shift = cfg.shift;

    assert_enable_tracks_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(win_en) |-> $past(reg_wr_en));
endmodule

// File: tb/tagmap_regfile_test.sv
`timescale 1ns/1ps
module tagmap_regfile_test;
    localparam int NC = 12;
    localparam logic [63:0] M0 = 64'hFFFF_FC01;
    localparam logic [63:0] M1 = 64'h1_FC07;

    logic clk = 0, rst_n = 0, wr = 0, rd = 0;
    logic [5:0] ra = '0;
    logic [63:0] wd = '0, rdat;
    logic rerr, pulse, en;
    logic [31:0] base;
    logic [17:0] size;
    logic [3:0] shift, view;
    logic [15:0] sa = '0;
    logic [3:0] cidx;
    int checks = 0, errors = 0;
    logic [63:0] m0, m1;

    always #2 clk = ~clk;

    tagmap_regfile #(.RA_W(6), .ST_AW(16), .NUM_CELLS(NC)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(wr), .reg_rd_en(rd), .reg_addr(ra),
        .reg_wdata(wd), .reg_rdata(rdat), .reg_rd_err(rerr), .rcfg_pulse(pulse),
        .win_base(base), .win_size(size), .win_en(en), .win_shift(shift),
        .st_addr(sa), .cell_idx(cidx), .st_view(view));

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rdslot(int s, output logic [63:0] v, output logic e);
        @(negedge clk); rd = 1; ra = 6'(s * 8); #1; v = rdat; e = rerr; rd = 0;
    endtask

    // Write and check the pulse in the cycle after the edge, then its fall.
    task automatic wslot(int s, logic [63:0] d, string req);
        logic chg = 0;
        if (s == 0) begin chg = (((d & M0) | (m0 & ~M0)) != m0); m0 = (d & M0) | (m0 & ~M0); end
        else if (s == 1) begin chg = (((d & M1) | (m1 & ~M1)) != m1); m1 = (d & M1) | (m1 & ~M1); end
        @(negedge clk); wr = 1; ra = 6'(s * 8); wd = d;
        @(posedge clk); #1; chk({req, " R5 pulse"}, 64'(pulse), 64'(chg));
        @(negedge clk); wr = 0;
        @(posedge clk); #1; chk("R5 single", 64'(pulse), 0);
    endtask

    task automatic chkwin();
        chk("R6 base", 64'(base), m0 & 64'hFFFF_FC00);
        chk("R6 en", 64'(en), 64'(m0[0]));
        chk("R6 size", 64'(size), 64'd1024 + (m1 & 64'h1FC00));
    endtask

    initial begin
        #800000;
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] v; logic e;
        logic [63:0] pats [6];
        pats = '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'hAAAA_AAAA_AAAA_AAAA,
                 64'h5555_5555_5555_5555, 64'h1234_5678_9ABC_DEF1, 64'h0};
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        m0 = 0; m1 = 64'hC00 | (64'(NC) << 20);
        #1;
        chk("R9 pulse", 64'(pulse), 0);
        chk("R9 size", 64'(size), 4096);
        rdslot(0, v, e); chk("R9 slot0", v, 0);
        rdslot(1, v, e); chk("R9 slot1", v, m1); chk("R1 no err", 64'(e), 0);

        for (int s = 0; s < 2; s++)
            for (int p = 0; p < 6; p++) begin
                wslot(s, pats[p], s == 0 ? "R2" : "R3");
                rdslot(0, v, e); chk("R2 slot0", v, m0);
                rdslot(1, v, e); chk("R3 slot1", v, m1);
                chkwin();
            end
        // Same-value write: no change, no pulse.
        wslot(1, m1, "R5 same");
        // Change only outside the mask: no pulse, no change.
        wslot(0, m0 | 64'hFFFF_FFFF_0000_0000, "R5 unmasked");
        rdslot(0, v, e); chk("R2 hi bits", v, m0);

        for (int s = 2; s < 8; s++) begin
            wslot(s, 64'hFFFF_FFFF_FFFF_FFFF, "R4");
            rdslot(0, v, e); chk("R4 slot0", v, m0);
            rdslot(1, v, e); chk("R4 slot1", v, m1);
            rdslot(s, v, e); chk("R1 oob data", v, 0); chk("R1 oob err", 64'(e), 1);
        end
        @(negedge clk); rd = 1; ra = 6'd13; #1;
        chk("R1 offset ignored", rdat, m1); rd = 0;

        for (int g = 0; g < 8; g++) begin
            wslot(1, 64'h1FC00 | 64'(g), "R3 grain");
            #1; chk("R7 shift", 64'(shift), 64'(7 + g));
            for (int c = 0; c < NC + 4; c++)
                for (int vw = 0; vw < 16; vw += 5) begin
                    logic [15:0] a;
                    logic [15:0] r;
                    a = 16'((c << (7 + g)) | (vw << 3) | (c & 7));
                    r = a >> (7 + g);
                    sa = a; #1;
                    chk("R7 cell", 64'(cidx), (r > 16'(NC - 1)) ? 64'(NC - 1) : 64'(r));
                    chk("R8 view", 64'(view), 64'(a[6:3]));
                end
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule